// File: doc/BRIEF.md
# Configurable Clock Gate with Aligned Control Signals

This block turns a free-running clock into a gated clock under the control of an enable input. It also hands back a copy of a vector of control signals, timed to suit logic that runs on the gated clock. The enable goes through a level-sensitive hold stage that is open only while the free clock is low. Once the free clock rises, the gated clock's high phase is fixed for that whole cycle. The gated clock therefore never carries a shortened or spurious pulse.

Two elaboration-time switches shape the block. When gating is switched off, the gated clock is the free clock itself and the control vector passes straight through. When gating is on and alignment delay is selected, the control vector is registered once on the free clock before it reaches the output. Those registers load a parameterised value under a synchronous, active-high reset. When delay is not selected, the vector passes straight through.

Top module: `clk_gate_align`

## Requirements
- R1: While the free clock is low, the gated clock is low in every configuration.
- R2: With gating enabled, the gated clock during a high phase of the free clock equals the enable value present at that rising edge. Enable changes during the high phase have no effect on the gated clock until the free clock has fallen.
- R3: With gating enabled, the enable is sampled transparently while the free clock is low. The last value before the rising edge decides whether that cycle produces a pulse (1 = pulse, 0 = no pulse).
- R4: With gating disabled, the gated clock equals the free clock and the enable input is ignored.
- R5: With gating enabled and delay selected, the control output equals the control input sampled at the previous rising edge of the free clock.
- R6: With gating enabled and delay selected, a rising edge with reset high loads the control output with the RESET_VALUE parameter, which is all zeros by default.
- R7: With gating enabled and delay not selected, the control output equals the control input in the same cycle.
- R8: With gating disabled, the control output equals the control input in the same cycle, even when delay is selected.
- R9: The delay registers run on the free clock, so they keep tracking the control input while the gated clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| freeClk | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous active-high reset for the delay registers |
| gateEn | input | 1 | Gating enable; 1 lets the clock through |
| ctrlIn | input | CTRL_WIDTH | Control vector from the free clock domain |
| gatedClk | output | 1 | Gated clock |
| ctrlOut | output | CTRL_WIDTH | Control vector aligned to the gated clock |

## Verification
The hardest case to reach from the ports is an enable change during the high phase of the free clock. A glitch-free gate must ignore it until the clock falls. The stimulus therefore inverts the enable a moment after each rising edge and samples the gated clock both before and after the flip. It then restores the intended enable in the low phase. During the run, the enable follows a pattern with long stopped stretches while an exhaustive sweep of the control vector is applied. This shows that the delayed outputs keep advancing while the gated clock is silent.

// File: rtl/clk_gate_align_pkg.sv
package clk_gate_align_pkg;

  typedef struct packed {
    logic useDelay;
    logic syncReset;
  } ctrlStrobes_t;

endpackage

// File: rtl/clk_gate_align_ctrl.sv
module clk_gate_align_ctrl
  import clk_gate_align_pkg::*;
#(
  parameter bit GATE_PRESENT = 1'b1,
  parameter bit DELAY_CTRL   = 1'b1
) (
  input  logic         freeClk,
  input  logic         rst,
  input  logic         gateEn,
  output logic         gatedClk,
  output ctrlStrobes_t strobes
);

  localparam bit DelayActive = GATE_PRESENT && DELAY_CTRL;

  generate
    if (GATE_PRESENT) begin : g_gate
      logic enHeld;
      // Open while the free clock is low; closed during the high phase.
      always_latch begin
        if (!freeClk) enHeld = gateEn;
      end
      assign gatedClk = freeClk & enHeld;
    end else begin : g_bypass
      logic unusedEn;
      assign unusedEn = gateEn;
      assign gatedClk = freeClk;
    end
  endgenerate

  always_comb begin
    strobes.useDelay  = DelayActive;
    strobes.syncReset = rst;
  end

endmodule

// File: rtl/clk_gate_align_dp.sv
module clk_gate_align_dp
  import clk_gate_align_pkg::*;
#(
  parameter int                  CTRL_WIDTH  = 8,
  parameter bit                  DELAY_BUILD = 1'b1,
  parameter logic [CTRL_WIDTH-1:0] RESET_VALUE = '0
) (
  input  logic                  freeClk,
  input  ctrlStrobes_t          strobes,
  input  logic [CTRL_WIDTH-1:0] ctrlIn,
  output logic [CTRL_WIDTH-1:0] ctrlOut
);

  generate
    if (DELAY_BUILD) begin : g_delay
      logic [CTRL_WIDTH-1:0] delayQ;
      for (genvar b = 0; b < CTRL_WIDTH; b++) begin : g_bit
        always_ff @(posedge freeClk) begin
          if (strobes.syncReset) delayQ[b] <= RESET_VALUE[b];
          else                   delayQ[b] <= ctrlIn[b];
        end
      end
      assign ctrlOut = strobes.useDelay ? delayQ : ctrlIn;
    end else begin : g_pass
      logic unusedStrobe;
      assign unusedStrobe = strobes.useDelay ^ strobes.syncReset;
      assign ctrlOut = ctrlIn;
    end
  endgenerate

endmodule

// File: rtl/clk_gate_align.sv
module clk_gate_align
  import clk_gate_align_pkg::*;
#(
  parameter bit                    GATE_PRESENT = 1'b1,
  parameter bit                    DELAY_CTRL   = 1'b1,
  parameter int                    CTRL_WIDTH   = 8,
  parameter logic [CTRL_WIDTH-1:0] RESET_VALUE  = '0
) (
  input  logic                  freeClk,
  input  logic                  rst,
  input  logic                  gateEn,
  input  logic [CTRL_WIDTH-1:0] ctrlIn,
  output logic                  gatedClk,
  output logic [CTRL_WIDTH-1:0] ctrlOut
);

  localparam bit DelayBuild = GATE_PRESENT && DELAY_CTRL;

  ctrlStrobes_t strobes;

  clk_gate_align_ctrl #(
    .GATE_PRESENT(GATE_PRESENT),
    .DELAY_CTRL  (DELAY_CTRL)
  ) u_ctrl (
    .freeClk (freeClk),
    .rst     (rst),
    .gateEn  (gateEn),
    .gatedClk(gatedClk),
    .strobes (strobes)
  );

  clk_gate_align_dp #(
    .CTRL_WIDTH (CTRL_WIDTH),
    .DELAY_BUILD(DelayBuild),
    .RESET_VALUE(RESET_VALUE)
  ) u_dp (
    .freeClk(freeClk),
    .strobes(strobes),
    .ctrlIn (ctrlIn),
    .ctrlOut(ctrlOut)
  );

endmodule

// File: rtl/clk_gate_align_chk.sv
module clk_gate_align_chk #(
  parameter bit                    GATE_PRESENT = 1'b1,
  parameter bit                    DELAY_CTRL   = 1'b1,
  parameter int                    CTRL_WIDTH   = 8,
  parameter logic [CTRL_WIDTH-1:0] RESET_VALUE  = '0
) (
  input logic                  freeClk,
  input logic                  rst,
  input logic                  gateEn,
  input logic [CTRL_WIDTH-1:0] ctrlIn,
  input logic                  gatedClk,
  input logic [CTRL_WIDTH-1:0] ctrlOut
);

  logic enAtRise;
  always_ff @(posedge freeClk) enAtRise <= gateEn;

  AST_LOW_WITH_FREE: assert property (@(posedge freeClk) disable iff (rst)
    !gatedClk); // R1

  generate
    if (GATE_PRESENT) begin : g_gate
      AST_HIGH_PHASE_HELD: assert property (@(negedge freeClk) disable iff (rst)
        gatedClk == enAtRise); // R2
    end else begin : g_bypass
      AST_BYPASS_CLOCK: assert property (@(negedge freeClk) disable iff (rst)
        gatedClk); // R4
    end

    if (GATE_PRESENT && DELAY_CTRL) begin : g_delay
      AST_DELAY_TRACK: assert property (@(posedge freeClk) disable iff (rst)
        !$past(rst) |-> ctrlOut == $past(ctrlIn)); // R5
      AST_RESET_LOAD: assert property (@(posedge freeClk) disable iff (rst)
        $past(rst) |-> ctrlOut == RESET_VALUE); // R6
    end else begin : g_pass
      AST_PASS_THROUGH: assert property (@(posedge freeClk) disable iff (rst)
        ctrlOut == ctrlIn); // R7
    end
  endgenerate

endmodule

bind clk_gate_align clk_gate_align_chk #(
  .GATE_PRESENT(GATE_PRESENT),
  .DELAY_CTRL  (DELAY_CTRL),
  .CTRL_WIDTH  (CTRL_WIDTH),
  .RESET_VALUE (RESET_VALUE)
) u_chk (
  .freeClk (freeClk),
  .rst     (rst),
  .gateEn  (gateEn),
  .ctrlIn  (ctrlIn),
  .gatedClk(gatedClk),
  .ctrlOut (ctrlOut)
);

// File: tb/clk_gate_align_test.sv
module clk_gate_align_test;

  localparam int ClkPeriod = 10;
  localparam int W = 8;
  localparam logic [W-1:0] Rv = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gateEn = 1'b0;
  logic [W-1:0] ctrlIn = '0;

  logic gcA, gcB, gcC, gcD;
  logic [W-1:0] coA, coB, coC, coD;

  int vectors = 0;
  int errors = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  // Gating on, delay on, non-zero reset value
  clk_gate_align #(.GATE_PRESENT(1'b1), .DELAY_CTRL(1'b1), .CTRL_WIDTH(W), .RESET_VALUE(Rv)) uut (
    .freeClk(clk), .rst(rst), .gateEn(gateEn), .ctrlIn(ctrlIn), .gatedClk(gcA), .ctrlOut(coA));
  // Gating on, delay off
  clk_gate_align #(.GATE_PRESENT(1'b1), .DELAY_CTRL(1'b0), .CTRL_WIDTH(W)) uutNoDelay (
    .freeClk(clk), .rst(rst), .gateEn(gateEn), .ctrlIn(ctrlIn), .gatedClk(gcB), .ctrlOut(coB));
  // Gating off, delay requested
  clk_gate_align #(.GATE_PRESENT(1'b0), .DELAY_CTRL(1'b1), .CTRL_WIDTH(W)) uutBypass (
    .freeClk(clk), .rst(rst), .gateEn(gateEn), .ctrlIn(ctrlIn), .gatedClk(gcC), .ctrlOut(coC));
  // Gating on, delay on, default reset value
  clk_gate_align #(.CTRL_WIDTH(W)) uutDefault (
    .freeClk(clk), .rst(rst), .gateEn(gateEn), .ctrlIn(ctrlIn), .gatedClk(gcD), .ctrlOut(coD));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  logic enCur = 1'b0;

  task automatic runCycle(input logic enNext, input logic [W-1:0] inVal, input logic rstNext);
    logic rstAtEdge;
    logic [W-1:0] prevIn;
    @(posedge clk);
    rstAtEdge = rst;
    prevIn = ctrlIn;
    #1 ctrlIn = inVal;
    #1;
    check(enCur ? "R2" : "R3", {7'd0, gcA}, {7'd0, enCur});
    check("R4 bypass high", {7'd0, gcC}, 8'd1);
    #1 gateEn = ~gateEn;              // change during high phase
    #1;
    check("R2 mid-high change", {7'd0, gcA}, {7'd0, enCur});
    check("R2 mid-high change nodelay inst", {7'd0, gcB}, {7'd0, enCur});
    check("R4 enable ignored", {7'd0, gcC}, 8'd1);
    #3;                               // free clock low
    check("R1 gated", {7'd0, gcA}, 8'd0);
    check("R1 bypass", {7'd0, gcC}, 8'd0);
    if (rstAtEdge) begin
      check("R6 reset value", coA, Rv);
      check("R6 default zero", coD, '0);
    end else begin
      check(enCur ? "R5" : "R9 gate stopped", coA, prevIn);
      check(enCur ? "R5 default inst" : "R9 default inst", coD, prevIn);
    end
    check("R7", coB, ctrlIn);
    check("R8", coC, ctrlIn);
    #1 gateEn = enNext;
    rst = rstNext;
    enCur = enNext;
  endtask

  initial begin : watchdog
    #(ClkPeriod * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // Reset state
    runCycle(1'b0, 8'h3C, 1'b1);
    runCycle(1'b1, 8'hC3, 1'b0);
    // Exhaustive sweep of the control vector with a patterned enable
    for (int k = 0; k < 256; k++) begin
      logic en;
      logic [W-1:0] v;
      en = ((k / 7) % 3) != 0;
      v = W'((k * 37 + 11) % 256);
      runCycle(en, v, (k == 120));
    end
    runCycle(1'b1, 8'h00, 1'b0);
    runCycle(1'b0, 8'hFF, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule